// File: doc/BRIEF.md
# Frame-Aligned Serial Port Enable Control

This block is the transmit and receive core of a synchronous serial port. It runs in network mode with a fixed number of time slots per frame. One bit clock and one frame sync are shared by both directions and are generated from the system clock. Words come from a small transmit FIFO and are shifted out MSB first. Received words are shifted in on the same bit clock and land in a small receive FIFO.

The design centres on when the enables take effect. Setting or clearing the transmit or receive enable never starts or cuts a frame part way through: activity changes only at the frame boundary. The enable is sampled once per frame, just before the second-to-last bit of the last slot. A disable that is undone before that point therefore leaves the stream running with no gap.

A gated-clock option makes the bit clock run only while the transmitter has work. The global enable empties both FIFOs, clears the sticky flags and halts the clock. The enable inputs themselves are left as they are, so the port resumes by the same frame rules once the global enable returns.

Top module: `sp_frame_port`

## Requirements
- R1: With gating off, the transmitter goes active only at a frame boundary, on the clock edge where fs_o falls. From that point the first slot carries the oldest transmit FIFO word, MSB first, with one bit per bit-clock period.
- R2: With gating off, clearing tx_en_i in the middle of a frame keeps the transmitter active until the end of that frame. It stops at the frame boundary.
- R3: The enable is sampled at the start of bit W-2 of the last slot. If it is high there, the transmitter stays active across the next boundary with no gap, even if it was low earlier in that frame. If it is raised only after that point, the transmitter stops at the boundary and resumes one frame later.
- R4: Receive activity follows the rules of R1 to R3 using rx_en_i. While active, each slot's W bits are sampled from rxd_i MSB first and pushed as one word into the receive FIFO at the end of the slot. rx_data_o shows the oldest word whenever rx_valid_o is high.
- R5: fs_o is high for exactly one bit period, during the last bit of the last slot, and repeats every W*SLOTS bit periods. Within each bit period, bclk_o is low for the first DIV/2 system cycles and high for the rest, and data changes at the start of the bit period.
- R6: The transmit FIFO accepts writes while tx_en_i is low. A write makes tx_empty_o go low on the next cycle and does not make the transmitter active.
- R7: If the transmit FIFO is empty when an active transmitter loads a slot, the slot is sent as all zeros and tx_underrun_o is set. It stays set until the global enable drops.
- R8: A received word that arrives while the receive FIFO is full is dropped and rx_overflow_o is set. It stays set until the global enable drops.
- R9: With gate_i high, the bit clock stays idle while tx_en_i is low. Raising tx_en_i makes the transmitter active on the next cycle and starts the clock at slot 0, bit 0. The first word is sent from that point.
- R10: With gate_i high, clearing tx_en_i lets the clock run until the word being shifted has completed its last bit. The clock then stops and the transmitter goes inactive.
- R11: While glob_en_i is low, both FIFOs are empty, both sticky flags are clear, both directions are inactive, and bclk_o and fs_o are low. When glob_en_i is raised with tx_en_i high and gating off, the transmitter becomes active at the first frame boundary, not before.
- R12: txd_o is low whenever the transmitter is inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en_i | input | 1 | Global enable; low flushes FIFOs and flags and halts the clock |
| tx_en_i | input | 1 | Transmit enable, applied at frame boundaries |
| rx_en_i | input | 1 | Receive enable, applied at frame boundaries |
| gate_i | input | 1 | Gated bit clock option |
| tx_wr_i | input | 1 | Transmit FIFO write strobe |
| tx_data_i | input | W | Transmit FIFO write data |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_rd_i | input | 1 | Receive FIFO read strobe |
| rx_data_o | output | W | Oldest received word |
| rx_valid_o | output | 1 | Receive FIFO holds at least one word |
| tx_underrun_o | output | 1 | Sticky transmit underrun flag |
| rx_overflow_o | output | 1 | Sticky receive overflow flag |
| tx_active_o | output | 1 | Transmitter active |
| rx_active_o | output | 1 | Receiver active |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync pulse |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
The hardest behaviour to reach from the ports is the late re-enable window. The result depends on which side of the one sampling bit, near the end of the last slot, the enable edge falls. The stimulus therefore aligns itself to the falling edge of the frame sync and counts system cycles to place the enable edge on a known bit position. It tests one edge well before the sampling bit, which must cause no gap, and one just after it, which must lose one frame. The serial output is looped back to the serial input, so every transmitted word must return through the receive FIFO. Running that loop with an empty transmit FIFO also drives the underrun and overflow paths.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Frame position events produced by the framer, one cycle wide each.
  typedef struct packed {
    logic bit_tick;   // last system cycle of a bit period
    logic slot_end;   // bit_tick on the last bit of a slot
    logic frame_end;  // slot_end on the last slot (frame boundary)
    logic samp;       // bit_tick entering bit W-2 of the last slot
    logic start;      // clock about to start running
  } sp_tick_t;

endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push, pop;

  always_comb begin
    empty_o = (cnt_q == '0);
    full_o  = (cnt_q == CNT_FULL);
    push    = wr_i && !full_o && !flush_i;
    pop     = rd_i && !empty_o && !flush_i;
    rdata_o = mem_q[rptr_q];
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sp_framer.sv
module sp_framer
  import sp_pkg::*;
#(
  parameter int W     = 8,
  parameter int SLOTS = 2,
  parameter int DIV   = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     glob_en_i,
  input  logic     gate_i,
  input  logic     tx_en_i,
  output sp_tick_t tick_o,
  output logic     run_d_o,
  output logic     bclk_o,
  output logic     fs_o
);
  localparam int DW = $clog2(DIV);
  localparam int BW = $clog2(W);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [DW-1:0] DIV_LAST  = DW'(DIV - 1);
  localparam logic [DW-1:0] DIV_HALF  = DW'(DIV / 2);
  localparam logic [BW-1:0] BIT_LAST  = BW'(W - 1);
  localparam logic [BW-1:0] BIT_SAMP  = BW'(W - 3);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic [DW-1:0] div_q, div_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          run_q, run_d;

  always_comb begin
    tick_o.bit_tick  = run_q && (div_q == DIV_LAST);
    tick_o.slot_end  = tick_o.bit_tick && (bit_q == BIT_LAST);
    tick_o.frame_end = tick_o.slot_end && (slot_q == SLOT_LAST);
    tick_o.samp      = tick_o.bit_tick && (slot_q == SLOT_LAST) && (bit_q == BIT_SAMP);

    if (gate_i) begin
      if (run_q) run_d = glob_en_i && !(tick_o.slot_end && !tx_en_i);
      else       run_d = glob_en_i && tx_en_i;
    end else begin
      run_d = glob_en_i;
    end
    tick_o.start = run_d && !run_q;
    run_d_o      = run_d;

    div_d  = div_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    if (!run_d || !run_q) begin
      div_d  = '0;
      bit_d  = '0;
      slot_d = '0;
    end else if (tick_o.bit_tick) begin
      div_d = '0;
      if (bit_q == BIT_LAST) begin
        bit_d  = '0;
        slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end else begin
      div_d = div_q + 1'b1;
    end

    bclk_o = run_q && (div_q >= DIV_HALF);
    fs_o   = run_q && (slot_q == SLOT_LAST) && (bit_q == BIT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      slot_q <= '0;
      run_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
      run_q  <= run_d;
    end
  end

endmodule

// File: rtl/sp_enable_ctl.sv
module sp_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic samp_i,
  input  logic bound_i,
  input  logic force_i,
  input  logic force_val_i,
  output logic active_o,
  output logic active_d_o
);
  logic samp_q, samp_d;
  logic act_q, act_d;

  always_comb begin
    if (clr_i)       samp_d = 1'b0;
    else if (samp_i) samp_d = en_i;
    else             samp_d = samp_q;

    if (clr_i)        act_d = 1'b0;
    else if (force_i) act_d = force_val_i;
    else if (bound_i) act_d = samp_q;
    else              act_d = act_q;

    active_o   = act_q;
    active_d_o = act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      act_q  <= act_d;
    end
  end

endmodule

// File: rtl/sp_frame_port.sv
module sp_frame_port
  import sp_pkg::*;
#(
  parameter int W     = 8,
  parameter int SLOTS = 2,
  parameter int DIV   = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         glob_en_i,
  input  logic         tx_en_i,
  input  logic         rx_en_i,
  input  logic         gate_i,
  input  logic         tx_wr_i,
  input  logic [W-1:0] tx_data_i,
  output logic         tx_full_o,
  output logic         tx_empty_o,
  input  logic         rx_rd_i,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o,
  output logic         tx_underrun_o,
  output logic         rx_overflow_o,
  output logic         tx_active_o,
  output logic         rx_active_o,
  output logic         bclk_o,
  output logic         fs_o,
  output logic         txd_o,
  input  logic         rxd_i
);
  sp_tick_t     tk;
  logic         run_d;
  logic         tx_act_d, rx_act_d;
  logic         tx_load;
  logic [W-1:0] tx_head;
  logic         rx_empty, rx_full, rx_push;
  logic [W-1:0] rx_word;
  logic [W-1:0] tx_sr_q, tx_sr_d, rx_sr_q, rx_sr_d;
  logic         und_q, und_d, ovf_q, ovf_d;

  sp_framer #(.W(W), .SLOTS(SLOTS), .DIV(DIV)) framer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_en_i (glob_en_i),
    .gate_i    (gate_i),
    .tx_en_i   (tx_en_i),
    .tick_o    (tk),
    .run_d_o   (run_d),
    .bclk_o    (bclk_o),
    .fs_o      (fs_o)
  );

  sp_enable_ctl tx_ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (!run_d),
    .en_i        (tx_en_i),
    .samp_i      (tk.samp),
    .bound_i     (tk.frame_end),
    .force_i     (gate_i),
    .force_val_i (run_d),
    .active_o    (tx_active_o),
    .active_d_o  (tx_act_d)
  );

  sp_enable_ctl rx_ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (!run_d),
    .en_i        (rx_en_i),
    .samp_i      (tk.samp),
    .bound_i     (tk.frame_end),
    .force_i     (1'b0),
    .force_val_i (1'b0),
    .active_o    (rx_active_o),
    .active_d_o  (rx_act_d)
  );

  sp_fifo #(.W(W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (!glob_en_i),
    .wr_i    (tx_wr_i),
    .wdata_i (tx_data_i),
    .rd_i    (tx_load),
    .rdata_o (tx_head),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o)
  );

  sp_fifo #(.W(W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (!glob_en_i),
    .wr_i    (rx_push),
    .wdata_i (rx_word),
    .rd_i    (rx_rd_i),
    .rdata_o (rx_data_o),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  always_comb begin
    tx_load = (gate_i && tk.start) || (tk.slot_end && tx_act_d);
    rx_push = tk.slot_end && rx_active_o;
    rx_word = {rx_sr_q[W-2:0], rxd_i};

    tx_sr_d = tx_sr_q;
    und_d   = und_q;
    if (!glob_en_i) begin
      tx_sr_d = '0;
      und_d   = 1'b0;
    end else if (tx_load) begin
      tx_sr_d = tx_empty_o ? '0 : tx_head;
      if (tx_empty_o) und_d = 1'b1;
    end else if (tk.bit_tick && tx_active_o) begin
      tx_sr_d = {tx_sr_q[W-2:0], 1'b0};
    end

    rx_sr_d = rx_sr_q;
    ovf_d   = ovf_q;
    if (!glob_en_i) begin
      rx_sr_d = '0;
      ovf_d   = 1'b0;
    end else begin
      if (tk.bit_tick && rx_active_o) rx_sr_d = rx_word;
      if (rx_push && rx_full)         ovf_d   = 1'b1;
    end

    txd_o         = tx_active_o && tx_sr_q[W-1];
    rx_valid_o    = !rx_empty;
    tx_underrun_o = und_q;
    rx_overflow_o = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      und_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
      und_q   <= und_d;
      ovf_q   <= ovf_d;
    end
  end

endmodule

// File: rtl/sp_frame_port_chk.sv
module sp_frame_port_chk (
  input logic clk,
  input logic rst_n,
  input logic glob_en_i,
  input logic gate_i,
  input logic tx_active_o,
  input logic rx_active_o,
  input logic fs_o,
  input logic txd_o,
  input logic bclk_o,
  input logic tx_empty_o,
  input logic rx_valid_o,
  input logic tx_underrun_o,
  input logic rx_overflow_o
);

  // R1: ungated transmit start coincides with the frame sync falling
  p_tx_start_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_active_o) && !gate_i && !$past(gate_i)) |-> $past(fs_o));

  // R2: ungated transmit stop only at the frame boundary
  p_tx_stop_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_active_o) && !gate_i && !$past(gate_i) && $past(glob_en_i)) |-> $past(fs_o));

  // R4: receive start always at a frame boundary
  p_rx_start_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active_o) |-> $past(fs_o));

  // R4: ungated receive stop only at the frame boundary
  p_rx_stop_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_active_o) && !$past(gate_i) && $past(glob_en_i)) |-> $past(fs_o));

  // R7: underrun flag is sticky while globally enabled
  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underrun_o && glob_en_i) |=> tx_underrun_o);

  // R8: overflow flag is sticky while globally enabled
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow_o && glob_en_i) |=> rx_overflow_o);

  // R9: gated clock idles while the transmitter is inactive
  p_gated_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && $past(gate_i) && !tx_active_o) |-> !bclk_o);

  // R11: global disable clears state and halts the clock
  p_global_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_i |=> (tx_empty_o && !rx_valid_o && !tx_underrun_o && !rx_overflow_o
                    && !bclk_o && !fs_o && !tx_active_o && !rx_active_o));

  // R12: serial output quiet while inactive
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active_o |-> !txd_o);

endmodule

bind sp_frame_port sp_frame_port_chk chk_i (.*);

// File: tb/sp_frame_port_tb_top.sv
`timescale 1ns/100ps
module sp_frame_port_tb_top;
  localparam int W = 8, SLOTS = 2, DIV = 4, DEPTH = 4;
  localparam int FRAME = W * SLOTS * DIV;

  logic clk = 1'b0;
  logic rst_n, glob_en, tx_en, rx_en, gate, tx_wr, rx_rd;
  logic [W-1:0] tx_data, rx_data;
  logic tx_full, tx_empty, rx_valid, und, ovf, tx_act, rx_act, bclk, fs, txd;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sp_frame_port #(.W(W), .SLOTS(SLOTS), .DIV(DIV), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .glob_en_i(glob_en), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .gate_i(gate), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_full_o(tx_full),
    .tx_empty_o(tx_empty), .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tx_underrun_o(und), .rx_overflow_o(ovf), .tx_active_o(tx_act), .rx_active_o(rx_act),
    .bclk_o(bclk), .fs_o(fs), .txd_o(txd), .rxd_i(txd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fs_fall();
    while (fs !== 1'b1) @(negedge clk);
    while (fs !== 1'b0) @(negedge clk);
  endtask

  task automatic write_tx(input logic [W-1:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx(output logic [W-1:0] d);
    @(negedge clk); d = rx_data; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic cap_bits(input int n, output logic [31:0] v);
    logic p;
    int i;
    v = '0; i = 0; p = bclk;
    while (i < n) begin
      @(negedge clk);
      if (bclk && !p) begin v = {v[30:0], txd}; i++; end
      p = bclk;
    end
  endtask

  task automatic count_rises(input int cyc, output int c);
    logic p;
    c = 0; p = bclk;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (bclk && !p) c++;
      p = bclk;
    end
  endtask

  task automatic t_reset();
    chk("R11 reset tx_empty", tx_empty, 1);
    chk("R11 reset rx_valid", rx_valid, 0);
    chk("R11 reset flags", {und, ovf}, 0);
    chk("R11 reset active", {tx_act, rx_act}, 0);
    chk("R11 reset clock", {bclk, fs}, 0);
    chk("R12 reset txd", txd, 0);
  endtask

  task automatic t_start();
    logic [31:0] v;
    logic [W-1:0] d;
    glob_en = 1'b1;
    write_tx(8'hA5);
    write_tx(8'h3C);
    chk("R6 write while disabled clears empty", tx_empty, 0);
    wait_fs_fall(); skip(8);
    tx_en = 1'b1; rx_en = 1'b1;
    skip(20);
    chk("R1 no mid-frame start", tx_act, 0);
    chk("R4 no mid-frame rx start", rx_act, 0);
    wait_fs_fall();
    chk("R1 active at boundary", tx_act, 1);
    chk("R4 rx active at boundary", rx_act, 1);
    cap_bits(16, v);
    chk("R1 serial words MSB first", v, 32'hA53C);
    skip(4);
    chk("R4 rx word available", rx_valid, 1);
    read_rx(d); chk("R4 rx first word", d, 8'hA5);
    read_rx(d); chk("R4 rx second word", d, 8'h3C);
  endtask

  task automatic t_underrun();
    logic [31:0] v;
    wait_fs_fall();
    chk("R7 underrun flag set", und, 1);
    cap_bits(16, v);
    chk("R7 zeros on underrun", v, 0);
  endtask

  task automatic t_overflow();
    logic [W-1:0] d;
    skip(3 * FRAME);
    wait_fs_fall();
    chk("R8 overflow flag set", ovf, 1);
    for (int i = 0; i < DEPTH; i++) begin
      read_rx(d);
      chk("R8 stored zero word", d, 0);
    end
    chk("R8 fifo held only depth words", rx_valid, 0);
  endtask

  task automatic t_fs();
    int c, per;
    while (fs !== 1'b1) @(negedge clk);
    c = 0;
    while (fs === 1'b1) begin c++; @(negedge clk); end
    chk("R5 fs width one bit", c, DIV);
    chk("R5 bclk low at bit start", bclk, 0);
    per = c;
    while (fs !== 1'b1) begin per++; @(negedge clk); end
    chk("R5 frame period", per, FRAME);
  endtask

  task automatic t_stop();
    int ones;
    wait_fs_fall(); skip(8);
    tx_en = 1'b0; rx_en = 1'b0;
    skip(40);
    chk("R2 still active before boundary", tx_act, 1);
    chk("R4 rx still active before boundary", rx_act, 1);
    wait_fs_fall();
    chk("R2 stopped at boundary", tx_act, 0);
    chk("R4 rx stopped at boundary", rx_act, 0);
    ones = 0;
    for (int i = 0; i < FRAME; i++) begin @(negedge clk); if (txd) ones++; end
    chk("R12 txd quiet while inactive", ones, 0);
  endtask

  task automatic t_late();
    int drops;
    tx_en = 1'b1;
    wait_fs_fall(); wait_fs_fall();
    chk("R3 active before test", tx_act, 1);
    skip(8); tx_en = 1'b0;
    skip(36); tx_en = 1'b1;
    drops = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!tx_act) drops++; end
    chk("R3 early re-enable no gap", drops, 0);
    wait_fs_fall(); skip(8); tx_en = 1'b0;
    skip(52); tx_en = 1'b1;
    wait_fs_fall();
    chk("R3 late re-enable loses frame", tx_act, 0);
    wait_fs_fall();
    chk("R3 resumes next boundary", tx_act, 1);
  endtask

  task automatic t_txwr();
    int ones, act;
    tx_en = 1'b0;
    wait_fs_fall(); wait_fs_fall();
    chk("R6 fifo empty before write", tx_empty, 1);
    write_tx(8'h77);
    chk("R6 write clears empty", tx_empty, 0);
    ones = 0; act = 0;
    for (int i = 0; i < FRAME + 8; i++) begin
      @(negedge clk);
      if (txd) ones++;
      if (tx_act) act++;
    end
    chk("R6 write does not activate", act, 0);
    chk("R12 txd quiet after write", ones, 0);
  endtask

  task automatic t_glob();
    int c;
    tx_en = 1'b1; rx_en = 1'b1;
    wait_fs_fall(); wait_fs_fall();
    glob_en = 1'b0;
    @(negedge clk);
    chk("R11 flush tx fifo", tx_empty, 1);
    chk("R11 flush rx fifo", rx_valid, 0);
    chk("R11 flags cleared", {und, ovf}, 0);
    chk("R11 inactive", {tx_act, rx_act}, 0);
    count_rises(30, c);
    chk("R11 clock halted", c, 0);
    glob_en = 1'b1;
    skip(30);
    chk("R11 no start before boundary", tx_act, 0);
    wait_fs_fall();
    chk("R11 restart at boundary", tx_act, 1);
  endtask

  task automatic t_gate();
    int c;
    logic [31:0] v;
    tx_en = 1'b0; rx_en = 1'b0; glob_en = 1'b0;
    skip(4);
    gate = 1'b1; glob_en = 1'b1;
    count_rises(40, c);
    chk("R9 gated clock idle", c, 0);
    write_tx(8'h96);
    write_tx(8'h5A);
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    chk("R9 immediate start", tx_act, 1);
    cap_bits(8, v);
    chk("R9 first gated word", v, 32'h96);
    cap_bits(3, v);
    chk("R10 head of second word", v, 32'h2);
    tx_en = 1'b0;
    count_rises(60, c);
    chk("R10 clock runs to word end", c, 5);
    chk("R10 inactive after word", tx_act, 0);
    chk("R10 clock stopped", bclk, 0);
  endtask

  initial begin
    rst_n = 1'b0; glob_en = 1'b0; tx_en = 1'b0; rx_en = 1'b0; gate = 1'b0;
    tx_wr = 1'b0; rx_rd = 1'b0; tx_data = '0;
    skip(5);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_underrun();
    t_overflow();
    t_fs();
    t_stop();
    t_late();
    t_txwr();
    t_glob();
    t_gate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule